// File: doc/BRIEF.md
# Downward-Growing Stack Pointer Unit

This block keeps the stack pointer of a small processor and turns stack requests into accesses on a byte-wide data memory. The pointer is 16 bits wide and software loads it one byte at a time, normally to the last RAM address. The stack grows toward lower addresses. A push writes at the pointer and then steps it down. A pop first steps the pointer up and then reads that slot.

A call stores a two-byte return address as two successive pushes, low byte first. A return reads the bytes back in the opposite order and rebuilds the address, then reports completion with a one-cycle strobe. Each of these sequences takes two cycles, and the block is busy for the second one.

The low part of the address space holds the register file and the I/O registers. The block flags any stack access that lands below the first RAM address. The memory array and instruction decoding live outside the block. The memory answers reads combinationally from `mem_addr`.

Top module: `stk_ptr_unit`

## Requirements
- R1: After reset the pointer is 0x0000, and `busy`, `mem_we`, `pop_valid` and `ret_done` are low.
- R2: `sp_hi_we` loads pointer bits 15:8 from `sp_wdata` and `sp_lo_we` loads bits 7:0. The other byte is kept. Both strobes together load both bytes with the same value.
- R3: A push drives `mem_we`=1, `mem_addr`=pointer and `mem_wdata`=`push_data` in its cycle. The pointer is one lower after that edge.
- R4: A pop drives `mem_addr`=pointer+1 and the pointer becomes pointer+1 at the edge. One cycle later `pop_valid` pulses with `pop_data` holding the byte read.
- R5: A call writes `call_ret_addr[7:0]` at the pointer and then, in the next cycle with `busy`=1, writes `call_ret_addr[15:8]` at pointer-1. The pointer ends two lower.
- R6: A return reads pointer+1 (the high byte) and then pointer+2 (the low byte) in the next cycle with `busy`=1. The pointer ends two higher. One cycle after the second read, `ret_done` pulses and `ret_addr` = {first byte, second byte}.
- R7: When idle, requests in the same cycle are served in this order: pointer byte write, call, return, push, pop. The lower ones have no effect in that cycle.
- R8: While `busy` is high, every new request, pointer writes included, is ignored.
- R9: `stack_err` is high in the cycle of any push or pop access whose memory address is below 0x0060. The access still takes place.
- R10: The pointer wraps modulo 2^16: a push at 0x0000 leaves 0xFFFF and a pop at 0xFFFF reads 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sp_hi_we | input | 1 | Load pointer high byte |
| sp_lo_we | input | 1 | Load pointer low byte |
| sp_wdata | input | 8 | Byte for pointer loads |
| push_req | input | 1 | Push one byte |
| push_data | input | 8 | Byte to push |
| pop_req | input | 1 | Pop one byte |
| call_req | input | 1 | Start a call sequence |
| call_ret_addr | input | 16 | Return address to save |
| ret_req | input | 1 | Start a return sequence |
| mem_rdata | input | 8 | Read data from memory at mem_addr |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| sp_out | output | 16 | Current stack pointer |
| pop_data | output | 8 | Byte returned by a pop |
| pop_valid | output | 1 | pop_data valid strobe |
| ret_addr | output | 16 | Restored return address |
| ret_done | output | 1 | Return complete strobe |
| busy | output | 1 | Second cycle of a call or return |
| stack_err | output | 1 | Access below the RAM start |

## Verification
Two functions can meet in one cycle. The first case is a pointer byte load that arrives together with a push, pop, call or return. The second is a new request that arrives during the second cycle of a call or return. Directed cycles raise these strobes together and then judge the result at the ports. The bench checks that no memory write appears for the losing request. It also checks that the pointer takes either the loaded value or the sequence's own step, never both. For a call, it checks that the high return byte is still what gets written.

// File: rtl/stk_pkg.sv
package stk_pkg;
  parameter int unsigned STK_DATA_W = 8;
  parameter int unsigned STK_ADDR_W = 2 * STK_DATA_W;

  typedef logic [STK_DATA_W-1:0] byte_t;
  typedef logic [STK_ADDR_W-1:0] addr_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CALL = 2'd1,
    ST_RET  = 2'd2
  } seq_st_t;

  // pointer after a push: one slot lower, wrapping
  function automatic addr_t sp_step_down(input addr_t a);
    return a - addr_t'(1);
  endfunction

  // pointer after a pop: one slot higher, wrapping
  function automatic addr_t sp_step_up(input addr_t a);
    return a + addr_t'(1);
  endfunction

  // true when an address falls in the register/I-O window
  function automatic logic addr_reserved(input addr_t a, input addr_t ram_start);
    return (a < ram_start);
  endfunction
endpackage

// File: rtl/stk_seq.sv
module stk_seq
  import stk_pkg::*;
#(
  parameter int unsigned RA_BYTES = 2,
  localparam int unsigned RA_W  = RA_BYTES * STK_DATA_W,
  localparam int unsigned CNT_W = $clog2(RA_BYTES + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sp_hi_we,
  input  logic            sp_lo_we,
  input  logic            call_req,
  input  logic            ret_req,
  input  logic            push_req,
  input  logic            pop_req,
  input  byte_t           push_data,
  input  logic [RA_W-1:0] call_ret_addr,
  input  byte_t           mem_rdata,
  output logic            op_push,
  output logic            op_pop,
  output logic            ld_hi,
  output logic            ld_lo,
  output byte_t           wr_byte,
  output byte_t           pop_data,
  output logic            pop_valid,
  output logic [RA_W-1:0] ret_addr,
  output logic            ret_done,
  output logic            busy
);
  seq_st_t         st;
  logic [CNT_W-1:0] cnt;
  logic [RA_W-1:0] ra_sh;
  logic [RA_W-1:0] acc;
  logic            start_call, start_ret, plain_pop;

  always_comb begin
    op_push    = 1'b0;
    op_pop     = 1'b0;
    ld_hi      = 1'b0;
    ld_lo      = 1'b0;
    wr_byte    = '0;
    start_call = 1'b0;
    start_ret  = 1'b0;
    plain_pop  = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (sp_hi_we || sp_lo_we) begin
          ld_hi = sp_hi_we;
          ld_lo = sp_lo_we;
        end else if (call_req) begin
          op_push    = 1'b1;
          wr_byte    = call_ret_addr[STK_DATA_W-1:0];
          start_call = 1'b1;
        end else if (ret_req) begin
          op_pop    = 1'b1;
          start_ret = 1'b1;
        end else if (push_req) begin
          op_push = 1'b1;
          wr_byte = push_data;
        end else if (pop_req) begin
          op_pop    = 1'b1;
          plain_pop = 1'b1;
        end
      end
      ST_CALL: begin
        op_push = 1'b1;
        wr_byte = ra_sh[STK_DATA_W-1:0];
      end
      ST_RET: op_pop = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      ra_sh     <= '0;
      acc       <= '0;
      pop_data  <= '0;
      pop_valid <= 1'b0;
      ret_done  <= 1'b0;
    end else begin
      pop_valid <= plain_pop;
      ret_done  <= 1'b0;
      if (plain_pop) pop_data <= mem_rdata;
      unique case (st)
        ST_IDLE: begin
          if (start_call) begin
            ra_sh <= call_ret_addr >> STK_DATA_W;
            cnt   <= CNT_W'(RA_BYTES - 1);
            st    <= ST_CALL;
          end else if (start_ret) begin
            acc <= RA_W'(mem_rdata);
            cnt <= CNT_W'(RA_BYTES - 1);
            st  <= ST_RET;
          end
        end
        ST_CALL: begin
          ra_sh <= ra_sh >> STK_DATA_W;
          cnt   <= cnt - CNT_W'(1);
          if (cnt == CNT_W'(1)) st <= ST_IDLE;
        end
        ST_RET: begin
          acc <= {acc[RA_W-STK_DATA_W-1:0], mem_rdata};
          cnt <= cnt - CNT_W'(1);
          if (cnt == CNT_W'(1)) begin
            st       <= ST_IDLE;
            ret_done <= 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign ret_addr = acc;
  assign busy     = (st != ST_IDLE);
endmodule

// File: rtl/stk_ptr_reg.sv
module stk_ptr_reg
  import stk_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ld_hi,
  input  logic  ld_lo,
  input  byte_t ld_byte,
  input  logic  op_push,
  input  logic  op_pop,
  output addr_t sp
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp <= '0;
    end else if (ld_hi || ld_lo) begin
      sp <= {ld_hi ? ld_byte : sp[STK_ADDR_W-1:STK_DATA_W],
             ld_lo ? ld_byte : sp[STK_DATA_W-1:0]};
    end else if (op_push) begin
      sp <= sp_step_down(sp);
    end else if (op_pop) begin
      sp <= sp_step_up(sp);
    end
  end
endmodule

// File: rtl/stk_mem_port.sv
module stk_mem_port
  import stk_pkg::*;
#(
  parameter addr_t RAM_START = addr_t'(16'h0060)
) (
  input  addr_t sp,
  input  logic  op_push,
  input  logic  op_pop,
  input  byte_t wr_byte,
  output addr_t mem_addr,
  output byte_t mem_wdata,
  output logic  mem_we,
  output logic  stack_err
);
  always_comb begin
    mem_addr  = op_pop ? sp_step_up(sp) : sp;
    mem_we    = op_push;
    mem_wdata = wr_byte;
    stack_err = (op_push || op_pop) && addr_reserved(mem_addr, RAM_START);
  end
endmodule

// File: rtl/stk_ptr_unit.sv
module stk_ptr_unit
  import stk_pkg::*;
#(
  parameter int unsigned RA_BYTES  = 2,
  parameter addr_t       RAM_START = addr_t'(16'h0060),
  localparam int unsigned RA_W = RA_BYTES * STK_DATA_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sp_hi_we,
  input  logic                  sp_lo_we,
  input  logic [STK_DATA_W-1:0] sp_wdata,
  input  logic                  push_req,
  input  logic [STK_DATA_W-1:0] push_data,
  input  logic                  pop_req,
  input  logic                  call_req,
  input  logic [RA_W-1:0]       call_ret_addr,
  input  logic                  ret_req,
  input  logic [STK_DATA_W-1:0] mem_rdata,
  output logic [STK_ADDR_W-1:0] mem_addr,
  output logic [STK_DATA_W-1:0] mem_wdata,
  output logic                  mem_we,
  output logic [STK_ADDR_W-1:0] sp_out,
  output logic [STK_DATA_W-1:0] pop_data,
  output logic                  pop_valid,
  output logic [RA_W-1:0]       ret_addr,
  output logic                  ret_done,
  output logic                  busy,
  output logic                  stack_err
);
  logic  op_push, op_pop, ld_hi, ld_lo;
  byte_t wr_byte;
  addr_t sp;

  stk_seq #(.RA_BYTES(RA_BYTES)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .sp_hi_we(sp_hi_we), .sp_lo_we(sp_lo_we),
    .call_req(call_req), .ret_req(ret_req),
    .push_req(push_req), .pop_req(pop_req),
    .push_data(push_data), .call_ret_addr(call_ret_addr),
    .mem_rdata(mem_rdata),
    .op_push(op_push), .op_pop(op_pop),
    .ld_hi(ld_hi), .ld_lo(ld_lo), .wr_byte(wr_byte),
    .pop_data(pop_data), .pop_valid(pop_valid),
    .ret_addr(ret_addr), .ret_done(ret_done), .busy(busy)
  );

  stk_ptr_reg u_ptr (
    .clk(clk), .rst_n(rst_n),
    .ld_hi(ld_hi), .ld_lo(ld_lo), .ld_byte(sp_wdata),
    .op_push(op_push), .op_pop(op_pop), .sp(sp)
  );

  stk_mem_port #(.RAM_START(RAM_START)) u_port (
    .sp(sp), .op_push(op_push), .op_pop(op_pop), .wr_byte(wr_byte),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .stack_err(stack_err)
  );

  assign sp_out = sp;
endmodule

// File: rtl/stk_chk.sv
module stk_chk
  import stk_pkg::*;
#(
  parameter addr_t RAM_START = addr_t'(16'h0060)
) (
  input logic  clk,
  input logic  rst_n,
  input logic  sp_hi_we,
  input logic  sp_lo_we,
  input addr_t sp_out,
  input addr_t mem_addr,
  input logic  mem_we,
  input logic  op_pop,
  input logic  stack_err,
  input logic  busy,
  input logic  ret_done
);
  p_reset_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (sp_out == '0 && !busy && !ret_done));

  p_push_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !(sp_hi_we || sp_lo_we) || mem_we && busy) |=> (sp_out == $past(mem_addr) - addr_t'(1)));

  p_pop_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    op_pop |=> (sp_out == $past(mem_addr)));

  p_call_second_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !busy) |=> (!busy || mem_we));

  p_ret_done_after_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ret_done |-> ($past(op_pop) && $past(busy) && !busy));

  p_load_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((sp_hi_we || sp_lo_we) && !busy) |-> (!mem_we && !op_pop));

  p_single_access_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $onehot({mem_we, op_pop}));

  p_err_only_access_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stack_err |-> ((mem_we || op_pop) && mem_addr < RAM_START));
endmodule

bind stk_ptr_unit stk_chk #(.RAM_START(RAM_START)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .sp_hi_we(sp_hi_we), .sp_lo_we(sp_lo_we),
  .sp_out(sp_out), .mem_addr(mem_addr), .mem_we(mem_we),
  .op_pop(op_pop), .stack_err(stack_err), .busy(busy),
  .ret_done(ret_done)
);

// File: tb/tb_stk_ptr_unit.sv
module tb_stk_ptr_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sp_hi_we = 0, sp_lo_we = 0, push_req = 0, pop_req = 0;
  logic        call_req = 0, ret_req = 0;
  logic [7:0]  sp_wdata = 0, push_data = 0;
  logic [15:0] call_ret_addr = 0;
  logic [7:0]  mem_rdata;
  logic [15:0] mem_addr, sp_out, ret_addr;
  logic [7:0]  mem_wdata, pop_data;
  logic        mem_we, pop_valid, ret_done, busy, stack_err;

  logic [7:0]  tb_mem  [256];
  logic [7:0]  ref_mem [256];
  logic [15:0] exp_sp;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  stk_ptr_unit dut (
    .clk(clk), .rst_n(rst_n),
    .sp_hi_we(sp_hi_we), .sp_lo_we(sp_lo_we), .sp_wdata(sp_wdata),
    .push_req(push_req), .push_data(push_data), .pop_req(pop_req),
    .call_req(call_req), .call_ret_addr(call_ret_addr), .ret_req(ret_req),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .sp_out(sp_out), .pop_data(pop_data),
    .pop_valid(pop_valid), .ret_addr(ret_addr), .ret_done(ret_done),
    .busy(busy), .stack_err(stack_err)
  );

  assign mem_rdata = tb_mem[mem_addr[7:0]];
  always @(posedge clk) if (mem_we) tb_mem[mem_addr[7:0]] <= mem_wdata;

  function automatic logic [15:0] m_dn(input logic [15:0] a); return a + 16'hFFFF; endfunction
  function automatic logic [15:0] m_up(input logic [15:0] a); return a + 16'h0001; endfunction
  function automatic logic m_err(input logic [15:0] a); return a <= 16'h005F; endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clr_in();
    sp_hi_we = 0; sp_lo_we = 0; push_req = 0; pop_req = 0;
    call_req = 0; ret_req = 0;
  endtask

  task automatic t_load(input logic hi, input logic lo, input logic [7:0] v);
    @(negedge clk); clr_in(); sp_hi_we = hi; sp_lo_we = lo; sp_wdata = v;
    #1 chk("R7 load no write", {31'd0, mem_we}, 0);
    @(posedge clk); #1;
    if (hi) exp_sp[15:8] = v;
    if (lo) exp_sp[7:0] = v;
    chk("R2 pointer load", {16'd0, sp_out}, {16'd0, exp_sp});
  endtask

  task automatic t_push(input logic [7:0] d);
    @(negedge clk); clr_in(); push_req = 1; push_data = d;
    #1;
    chk("R3 push we", {31'd0, mem_we}, 1);
    chk("R3 push addr", {16'd0, mem_addr}, {16'd0, exp_sp});
    chk("R3 push data", {24'd0, mem_wdata}, {24'd0, d});
    chk("R9 push err", {31'd0, stack_err}, {31'd0, m_err(exp_sp)});
    ref_mem[exp_sp[7:0]] = d;
    exp_sp = m_dn(exp_sp);
    @(posedge clk); #1;
    chk("R3 push step", {16'd0, sp_out}, {16'd0, exp_sp});
  endtask

  task automatic t_pop();
    logic [7:0] e;
    @(negedge clk); clr_in(); pop_req = 1;
    #1;
    exp_sp = m_up(exp_sp);
    e = ref_mem[exp_sp[7:0]];
    chk("R4 pop addr", {16'd0, mem_addr}, {16'd0, exp_sp});
    chk("R4 pop no write", {31'd0, mem_we}, 0);
    chk("R9 pop err", {31'd0, stack_err}, {31'd0, m_err(exp_sp)});
    @(posedge clk); #1;
    chk("R4 pop step", {16'd0, sp_out}, {16'd0, exp_sp});
    chk("R4 pop valid", {31'd0, pop_valid}, 1);
    chk("R4 pop data", {24'd0, pop_data}, {24'd0, e});
  endtask

  // stray: raise other requests during the busy cycle (R8)
  task automatic t_call(input logic [15:0] ra, input logic stray);
    @(negedge clk); clr_in(); call_req = 1; call_ret_addr = ra;
    if (stray) push_req = 1;
    #1;
    chk("R5 call low addr", {16'd0, mem_addr}, {16'd0, exp_sp});
    chk("R5 call low data", {24'd0, mem_wdata}, {24'd0, ra[7:0]});
    ref_mem[exp_sp[7:0]] = ra[7:0];
    exp_sp = m_dn(exp_sp);
    @(posedge clk);
    @(negedge clk); clr_in(); call_ret_addr = 16'h0000;
    if (stray) begin sp_hi_we = 1; sp_wdata = 8'h33; push_req = 1; push_data = 8'hEE; call_req = 1; end
    #1;
    chk("R5 call busy", {31'd0, busy}, 1);
    chk("R5 call high we", {31'd0, mem_we}, 1);
    chk("R5 call high addr", {16'd0, mem_addr}, {16'd0, exp_sp});
    chk("R8 call high data", {24'd0, mem_wdata}, {24'd0, ra[15:8]});
    ref_mem[exp_sp[7:0]] = ra[15:8];
    exp_sp = m_dn(exp_sp);
    @(posedge clk); #1;
    chk("R8 call pointer", {16'd0, sp_out}, {16'd0, exp_sp});
    chk("R5 call idle", {31'd0, busy}, 0);
  endtask

  task automatic t_ret(input logic stray);
    logic [15:0] e;
    @(negedge clk); clr_in(); ret_req = 1;
    if (stray) pop_req = 1;
    #1;
    exp_sp = m_up(exp_sp);
    e[15:8] = ref_mem[exp_sp[7:0]];
    chk("R6 ret first addr", {16'd0, mem_addr}, {16'd0, exp_sp});
    @(posedge clk);
    @(negedge clk); clr_in();
    if (stray) begin sp_lo_we = 1; sp_wdata = 8'h44; pop_req = 1; ret_req = 1; end
    #1;
    exp_sp = m_up(exp_sp);
    e[7:0] = ref_mem[exp_sp[7:0]];
    chk("R6 ret busy", {31'd0, busy}, 1);
    chk("R6 ret second addr", {16'd0, mem_addr}, {16'd0, exp_sp});
    chk("R8 ret no write", {31'd0, mem_we}, 0);
    @(posedge clk); #1;
    chk("R6 ret done", {31'd0, ret_done}, 1);
    chk("R6 ret addr", {16'd0, ret_addr}, {16'd0, e});
    chk("R8 ret pointer", {16'd0, sp_out}, {16'd0, exp_sp});
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) begin tb_mem[i] = 8'h00; ref_mem[i] = 8'h00; end
    exp_sp = 16'h0000;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset pointer", {16'd0, sp_out}, 0);
    chk("R1 reset busy", {31'd0, busy}, 0);
    chk("R1 reset pop_valid", {31'd0, pop_valid}, 0);
    chk("R1 reset ret_done", {31'd0, ret_done}, 0);
    @(negedge clk); rst_n = 1;
    #1 chk("R1 reset we", {31'd0, mem_we}, 0);

    // R10 wrap both ways from reset value
    t_push(8'hA5);
    chk("R10 wrap down", {16'd0, sp_out}, 32'h0000FFFF);
    t_pop();
    chk("R10 wrap up", {16'd0, sp_out}, 0);

    // R2 separate and joint byte loads
    t_load(1, 0, 8'h01);
    t_load(0, 1, 8'h7F);
    t_load(1, 1, 8'h02);
    t_load(1, 0, 8'h00);
    t_load(0, 1, 8'h61);

    // R9 boundary at the RAM start
    t_push(8'h11);
    t_push(8'h22);
    t_push(8'h33);
    t_pop();
    t_pop();
    t_pop();

    // R7 priority: load beats push
    @(negedge clk); clr_in(); sp_lo_we = 1; sp_wdata = 8'hF0; push_req = 1; pop_req = 1;
    #1 chk("R7 load beats push", {31'd0, mem_we}, 0);
    @(posedge clk); #1; exp_sp[7:0] = 8'hF0;
    chk("R7 pointer after clash", {16'd0, sp_out}, {16'd0, exp_sp});
    // push beats pop
    @(negedge clk); clr_in(); push_req = 1; pop_req = 1; push_data = 8'h5A;
    #1 chk("R7 push beats pop", {16'd0, mem_addr}, {16'd0, exp_sp});
    ref_mem[exp_sp[7:0]] = 8'h5A; exp_sp = m_dn(exp_sp);
    @(posedge clk); #1 chk("R7 pop_valid quiet", {31'd0, pop_valid}, 0);

    // R5/R6 sequences, call beats push and ret beats pop, stray traffic in busy cycle
    t_call(16'hBEEF, 1);
    t_ret(1);
    t_call(16'h1234, 0);
    t_call(16'h5678, 0);
    t_ret(0);
    t_ret(0);

    for (int k = 0; k < 300; k++) begin
      int unsigned r;
      r = $urandom % 5;
      case (r)
        0: t_push(8'($urandom));
        1: t_pop();
        2: t_call(16'($urandom), 1'($urandom));
        3: t_ret(1'($urandom));
        default: begin
          @(negedge clk); clr_in();
          @(posedge clk); #1 chk("R4 idle quiet", {30'd0, pop_valid, ret_done}, 0);
        end
      endcase
    end
    finish_run();
  end
endmodule